// File: doc/BRIEF.md
# Programmable Even Clock Output Channel

This block is one output lane of a clock distribution tree. Its input clock has already been divided by an upstream stage. The lane can pass that clock straight through, or divide it by an even ratio that equals twice an 8-bit code. The overall ratio at the pin is therefore the upstream ratio times twice the code. Codes from 1 to 255 give ratios from 2 to 510. Code 1, ratio 2, is the value configuration software loads after reset. Code 0 is not a legal ratio.

A 2-bit mode field selects whether the divider sits in the path. The two delayed modes carry a fine analog delay stage, which is outside this block and is modelled here as a wire. An active-low sync input restarts the divider from phase zero, so lanes released together keep aligned edges. The output is live only when the lane enable, the global enable and the output-enable pin are all high. Otherwise it is driven low.

Top module: `clk_out_chan`

## Requirements
- R1: While rst_ni is low in a dividing mode, clk_o is low, and the divider restarts from phase zero when reset is released.
- R2: In a dividing mode with code N (1..255) and all enables high, clk_o toggles on every N-th rising edge of clk_i. The period is 2N input cycles with a 50% duty cycle. The first rise comes on the N-th rising edge after sync is released.
- R3: With code 0 in a dividing mode, clk_o stays low.
- R4: Mode encoding: 2'b00 is bypass and 2'b01 is delayed. In both, clk_o follows clk_i undivided. 2'b10 is divided and 2'b11 is divided-and-delayed. In both, the divider output drives clk_o.
- R5: While sync_ni is low, the divider state and its output are held at zero. After release, counting starts from zero, so a mid-run sync realigns the phase.
- R6: clk_o is low unless chan_en_i, glob_en_i and oe_pin_i are all high. Either the global bit or the pin overrides the lane enable.
- R7: Gating the output off and back on does not disturb the divider phase. The counter keeps running while clk_o is held low.
- R8: If the code is lowered below the current count, the divider wraps and toggles on the next rising edge, then runs at the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock from the upstream divider |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_ni | input | 1 | Divider phase realignment, active low |
| div_code_i | input | 8 | Divide code; the ratio is twice this value |
| mode_i | input | 2 | Path mode: bypass, delayed, divided, divided-and-delayed |
| chan_en_i | input | 1 | Lane output enable |
| glob_en_i | input | 1 | Global output enable |
| oe_pin_i | input | 1 | Output-enable pin level |
| clk_o | output | 1 | Lane output clock |

## Verification
The divider output is registered, so a change of code or sync takes effect at the first rising edge of clk_i after it. The output for that edge is read 3 time units later, while clk_i is still high. Enable gating and the bypass path are combinational, so their effect is visible in the same half cycle. The bench therefore checks bypass by sampling once inside the high phase and once inside the low phase. Every dividing scenario counts rising edges from sync release. It checks each sample against the toggle count computed from the code.

// File: rtl/clk_chan_pkg.sv
package clk_chan_pkg;
  localparam int unsigned CODE_W = 8;

  typedef enum logic [1:0] {
    MODE_BYPASS    = 2'b00,
    MODE_DELAY     = 2'b01,
    MODE_DIV       = 2'b10,
    MODE_DIV_DELAY = 2'b11
  } chan_mode_e;

  // bit 1 of the mode puts the divider in the path
  function automatic logic mode_divides(logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/even_div.sv
module even_div #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              div_o
);
  logic [CODE_W-1:0] cnt_q;
  logic              div_q;
  logic              code_zero;
  logic              term;

  assign code_zero = (code_i == '0);
  // >= so a lowered code wraps at once
  assign term      = (cnt_q >= CODE_W'(code_i - CODE_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (!sync_ni || code_zero) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      div_q <= ~div_q;
    end else begin
      cnt_q <= cnt_q + CODE_W'(1);
    end
  end

  assign div_o = div_q;

  AST_SYNC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_ni |=> (cnt_q == '0) && !div_q); // R5
  AST_ZERO_CODE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == '0) |=> !div_q); // R3
  AST_TOGGLE_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_ni && $past(sync_ni) && (div_q != $past(div_q))) |-> (cnt_q == '0)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != '0) && (code_i == $past(code_i)) |-> (cnt_q < code_i)); // R8
endmodule

// File: rtl/out_gate.sv
module out_gate (
  input  logic       clk_i,
  input  logic       div_i,
  input  logic [1:0] mode_i,
  input  logic       chan_en_i,
  input  logic       glob_en_i,
  input  logic       oe_pin_i,
  output logic       clk_o
);
  import clk_chan_pkg::*;

  logic path_clk;
  logic live;

  // delay stage is external; delayed modes pass straight through
  assign path_clk = mode_divides(mode_i) ? div_i : clk_i;
  assign live     = chan_en_i & glob_en_i & oe_pin_i;
  assign clk_o    = live ? path_clk : 1'b0;
endmodule

// File: rtl/clk_out_chan.sv
module clk_out_chan #(
  parameter int unsigned CODE_W = clk_chan_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_ni,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic [1:0]        mode_i,
  input  logic              chan_en_i,
  input  logic              glob_en_i,
  input  logic              oe_pin_i,
  output logic              clk_o
);
  logic div_clk;

  even_div #(.CODE_W(CODE_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_ni (sync_ni),
    .code_i  (div_code_i),
    .div_o   (div_clk)
  );

  out_gate u_gate (
    .clk_i     (clk_i),
    .div_i     (div_clk),
    .mode_i    (mode_i),
    .chan_en_i (chan_en_i),
    .glob_en_i (glob_en_i),
    .oe_pin_i  (oe_pin_i),
    .clk_o     (clk_o)
  );

  AST_DIV_OFF_IN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_ni && mode_i[1]) |=> (mode_i[1] ? !clk_o : 1'b1)); // R5
endmodule

// File: tb/clk_out_chan_tb.sv
module clk_out_chan_tb;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_n = 1'b1;
  logic [7:0] code = 8'd1;
  logic [1:0] mode = 2'b10;
  logic       chan_en = 1'b1;
  logic       glob_en = 1'b1;
  logic       oe_pin = 1'b1;
  logic       clk_o;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  clk_out_chan u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sync_ni    (sync_n),
    .div_code_i (code),
    .mode_i     (mode),
    .chan_en_i  (chan_en),
    .glob_en_i  (glob_en),
    .oe_pin_i   (oe_pin),
    .clk_o      (clk_o)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: clk_o=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // advance to just after the next rising edge
  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  task automatic resync();
    sync_n = 1'b0;
    tick();
    tick();
    sync_n = 1'b1;
  endtask

  task automatic run_div(input logic [7:0] n, input logic [1:0] m, input string req);
    code = n;
    mode = m;
    resync();
    for (int k = 1; k <= 4 * int'(n); k++) begin
      tick();
      check(clk_o, logic'(((k / int'(n)) % 2) == 1), req);
    end
  endtask

  task automatic t_reset();
    mode = 2'b10;
    code = 8'd1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(clk_o, 1'b0, "R1 in reset");
    end
    rst_n = 1'b1;
    // first edge after release: code 1 toggles high
    tick();
    check(clk_o, 1'b1, "R1 first edge after reset");
  endtask

  task automatic t_ratios();
    run_div(8'd1, 2'b10, "R2 ratio 2");
    run_div(8'd3, 2'b10, "R2 ratio 6");
    run_div(8'd255, 2'b10, "R2 ratio 510");
    run_div(8'd4, 2'b11, "R4 div-delay ratio 8");
  endtask

  task automatic t_zero_code();
    code = 8'd0;
    mode = 2'b10;
    for (int i = 0; i < 6; i++) begin
      tick();
      check(clk_o, 1'b0, "R3 code zero");
    end
  endtask

  task automatic t_bypass();
    code = 8'd5;
    for (int mi = 0; mi < 2; mi++) begin
      mode = 2'(mi);
      for (int i = 0; i < 3; i++) begin
        @(posedge clk);
        #2;
        check(clk_o, 1'b1, "R4 pass-through high");
        #5;
        check(clk_o, 1'b0, "R4 pass-through low");
      end
    end
    mode = 2'b00;
    glob_en = 1'b0;
    @(posedge clk);
    #2;
    check(clk_o, 1'b0, "R6 bypass global off");
    glob_en = 1'b1;
  endtask

  task automatic t_sync();
    code = 8'd2;
    mode = 2'b10;
    resync();
    tick();
    tick();
    check(clk_o, 1'b1, "R5 running before resync");
    sync_n = 1'b0;
    tick();
    check(clk_o, 1'b0, "R5 held in sync");
    tick();
    check(clk_o, 1'b0, "R5 held in sync");
    sync_n = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      check(clk_o, logic'(((k / 2) % 2) == 1), "R5 phase after release");
    end
  endtask

  task automatic t_enables();
    code = 8'd1;
    mode = 2'b10;
    resync();
    for (int which = 0; which < 3; which++) begin
      chan_en = (which != 0);
      glob_en = (which != 1);
      oe_pin  = (which != 2);
      for (int i = 0; i < 2; i++) begin
        tick();
        check(clk_o, 1'b0, "R6 one enable low");
      end
    end
    chan_en = 1'b1;
    glob_en = 1'b1;
    oe_pin  = 1'b1;
  endtask

  task automatic t_phase_keep();
    code = 8'd2;
    mode = 2'b10;
    resync();
    for (int k = 1; k <= 8; k++) begin
      chan_en = !(k == 4 || k == 5);
      tick();
      if (k == 4 || k == 5)
        check(clk_o, 1'b0, "R7 gated off");
      else
        check(clk_o, logic'(((k / 2) % 2) == 1), "R7 phase kept");
    end
    chan_en = 1'b1;
  endtask

  task automatic t_code_lower();
    code = 8'd10;
    mode = 2'b10;
    resync();
    for (int k = 1; k <= 7; k++) tick();
    check(clk_o, 1'b0, "R8 before change");
    code = 8'd3;
    for (int k = 1; k <= 7; k++) begin
      tick();
      check(clk_o, logic'((((k - 1) / 3 + 1) % 2) == 1), "R8 after lowering");
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ratios();
    t_zero_code();
    t_bypass();
    t_sync();
    t_enables();
    t_phase_keep();
    t_code_lower();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule